// File: doc/BRIEF.md
# Multi-Range Memory Clearing Sequencer

This block fills ECC-protected memory with a known all-zero pattern so that every line carries valid check bits before normal traffic begins. It holds a base, an inclusive limit and an enable flag for each of up to eight address ranges, all in cache-line units. It issues one write per line through a valid/ready request port. Software drives it through one 32-bit control word. The low bits each request the clearing of one range. The top bit requests a sweep over every enabled range in ascending index order.

Software only sets bits. Hardware clears each bit when its work has finished, so reading the control word shows what is still outstanding. Range requests that are pending together are taken one at a time. At each boundary between ranges, single-range requests take priority over the sweep. A disabled range costs one decision cycle and receives no writes.

Top module: `range_clear_seq`

## Requirements
- R1: After reset the control word reads zero, `busy` is low and `wrValid` is low.
- R2: Writing 1 to bit i (i below the range count) of an enabled range issues writes to every line from base to limit inclusive, in ascending order, with all-zero data. Bit i then clears on the clock edge that accepts the last write.
- R3: While `wrValid` is high and `wrReady` is low, `wrValid` stays high and `wrAddr` stays stable. The address advances by one only on a cycle where both are high.
- R4: Per-range bits pending together are serviced one range at a time, lowest index first. At most one per-range bit clears in any cycle.
- R5: Bit 31 starts a sweep of the enabled ranges from index 0 upward. Bit 31 stays set until the highest index has been handled, and then clears.
- R6: A disabled range receives no writes. During a sweep it is passed over in one cycle. A per-range bit written for a disabled range clears on the next clock edge.
- R7: Bits 30 down to the range count read as zero and ignore writes. Writing only those bits leaves `busy` low.
- R8: Writing 0 to a set bit does not stop the work in progress. Writing 1 to a bit that is already set does not restart its range.
- R9: `busy` is high exactly when any control bit is set.
- R10: A per-range bit written while a sweep is running is serviced at the next range boundary. The sweep then continues from the next index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 32 | Control word write data (ones set bits) |
| regRdData | output | 32 | Current control word |
| rangeBase | input | NUM_RANGES*ADDR_W | Packed per-range first line address |
| rangeLimit | input | NUM_RANGES*ADDR_W | Packed per-range last line address (inclusive) |
| rangeEnable | input | NUM_RANGES | Per-range enable |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Memory port accepts the write |
| wrAddr | output | ADDR_W | Line address of the write |
| wrData | output | DATA_W | Write data, always zero |
| busy | output | 1 | Any control bit set |

## Verification
A wrong range index or a stale sweep pointer shows up as a write address outside the expected list. The bench sees it on the first accepted write of the affected range. A stepping fault shows within one accepted transfer, as a skipped or repeated line or as an address that moves during a stall. A wrong clear decision leaves a bit stuck, or drops it early, in the readable control word and in `busy`. That is visible within a cycle of the last write of the range, or within a cycle of a write to a disabled range.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef struct packed {
    logic load;   // capture base/limit of pickIdx
    logic step;   // advance to the next line
  } dpCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;
endpackage

// File: rtl/rcs_addr_path.sv
module rcs_addr_path
  import rcs_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 16,
  localparam int IDX_W     = $clog2(NUM_RANGES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCmd_t                       dpCmd,
  input  logic [IDX_W-1:0]             pickIdx,
  input  logic [NUM_RANGES*ADDR_W-1:0] rangeBase,
  input  logic [NUM_RANGES*ADDR_W-1:0] rangeLimit,
  output logic [ADDR_W-1:0]            curAddr,
  output logic                         atLimit
);
  logic [ADDR_W-1:0] baseArr [NUM_RANGES];
  logic [ADDR_W-1:0] limArr  [NUM_RANGES];
  logic [ADDR_W-1:0] curLimit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_unpack
    assign baseArr[g] = rangeBase[g*ADDR_W +: ADDR_W];
    assign limArr[g]  = rangeLimit[g*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curLimit <= '0;
    end else if (dpCmd.load) begin
      curAddr  <= baseArr[pickIdx];
      curLimit <= limArr[pickIdx];
    end else if (dpCmd.step) begin
      curAddr  <= curAddr + ADDR_W'(1);
    end
  end

  assign atLimit = (curAddr == curLimit);

  // R3: the control never steps past the captured limit
  p_step_below_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    dpCmd.step |-> (curAddr != curLimit));
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int REG_W      = 32,
  parameter int ALL_BIT    = 31,
  localparam int IDX_W     = $clog2(NUM_RANGES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [NUM_RANGES-1:0] rangeEnable,
  input  logic                  wrReady,
  input  logic                  atLimit,
  output logic                  wrValid,
  output logic                  busy,
  output dpCmd_t                dpCmd,
  output logic [IDX_W-1:0]      pickIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RANGES - 1);

  seqState_e             state, nextState;
  logic [NUM_RANGES-1:0] perBits, perClr, perSet;
  logic                  allBit, allClr, allSet;
  logic [IDX_W-1:0]      sweepIdx, curIdx, lowIdx;
  logic                  curIsSweep, pickSweep, sweepAdv;

  always_comb begin
    lowIdx = '0;
    for (int k = NUM_RANGES - 1; k >= 0; k--)
      if (perBits[k]) lowIdx = IDX_W'(k);
  end

  always_comb begin
    nextState = state;
    dpCmd     = '0;
    pickIdx   = sweepIdx;
    pickSweep = 1'b0;
    perClr    = '0;
    sweepAdv  = 1'b0;
    wrValid   = (state == ST_RUN);
    case (state)
      ST_IDLE: begin
        if (|perBits) begin
          pickIdx = lowIdx;
          if (rangeEnable[lowIdx]) begin
            dpCmd.load = 1'b1;
            nextState  = ST_RUN;
          end else begin
            perClr[lowIdx] = 1'b1;
          end
        end else if (allBit) begin
          pickSweep = 1'b1;
          if (rangeEnable[sweepIdx]) begin
            dpCmd.load = 1'b1;
            nextState  = ST_RUN;
          end else begin
            sweepAdv = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (wrReady) begin
          if (atLimit) begin
            nextState = ST_IDLE;
            if (curIsSweep) sweepAdv = 1'b1;
            else            perClr[curIdx] = 1'b1;
          end else begin
            dpCmd.step = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign allClr = sweepAdv && (sweepIdx == LAST_IDX);
  assign perSet = regWrEn ? regWrData[NUM_RANGES-1:0] : '0;
  assign allSet = regWrEn && regWrData[ALL_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      perBits    <= '0;
      allBit     <= 1'b0;
      sweepIdx   <= '0;
      curIdx     <= '0;
      curIsSweep <= 1'b0;
    end else begin
      state   <= nextState;
      perBits <= (perBits | perSet) & ~perClr;
      allBit  <= (allBit | allSet) & ~allClr;
      if (sweepAdv) sweepIdx <= allClr ? '0 : sweepIdx + IDX_W'(1);
      if (dpCmd.load) begin
        curIdx     <= pickIdx;
        curIsSweep <= pickSweep;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[NUM_RANGES-1:0] = perBits;
    regRdData[ALL_BIT]        = allBit;
  end
  assign busy = (|perBits) | allBit;

  // R2: no control bit rises without a software write
  p_no_spont_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((regRdData & ~$past(regRdData)) == '0));
  // R4: ranges finish one at a time
  p_single_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($countones($past(perBits) & ~perBits) <= 1));
  // R5: the sweep bit drops only after the last index was handled
  p_sweep_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(allBit) |-> ($past(sweepIdx) == LAST_IDX));
endmodule

// File: rtl/range_clear_seq.sv
module range_clear_seq
  import rcs_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 64,
  localparam int REG_W     = 32,
  localparam int ALL_BIT   = 31,
  localparam int IDX_W     = $clog2(NUM_RANGES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [REG_W-1:0]             regWrData,
  output logic [REG_W-1:0]             regRdData,
  input  logic [NUM_RANGES*ADDR_W-1:0] rangeBase,
  input  logic [NUM_RANGES*ADDR_W-1:0] rangeLimit,
  input  logic [NUM_RANGES-1:0]        rangeEnable,
  output logic                         wrValid,
  input  logic                         wrReady,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [DATA_W-1:0]            wrData,
  output logic                         busy
);
  dpCmd_t           dpCmd;
  logic [IDX_W-1:0] pickIdx;
  logic             atLimit;

  rcs_ctrl #(.NUM_RANGES(NUM_RANGES), .REG_W(REG_W), .ALL_BIT(ALL_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rangeEnable(rangeEnable), .wrReady(wrReady),
    .atLimit(atLimit), .wrValid(wrValid), .busy(busy), .dpCmd(dpCmd),
    .pickIdx(pickIdx)
  );

  rcs_addr_path #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) path_i (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .pickIdx(pickIdx),
    .rangeBase(rangeBase), .rangeLimit(rangeLimit),
    .curAddr(wrAddr), .atLimit(atLimit)
  );

  assign wrData = '0;

  // R3: a stalled request holds its address
  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr)));
  // R3: an accepted non-final write moves to the next line
  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !atLimit) |=> (wrAddr == $past(wrAddr) + ADDR_W'(1)));
  // R9: busy only rises through a software write
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn));
endmodule

// File: tb/range_clear_seq_tb_top.sv
`timescale 1ns/100ps
module range_clear_seq_tb_top;
  localparam int N = 8, AW = 16, DW = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, regWrEn, wrValid, wrReady, busy;
  logic [31:0]   regWrData, regRdData;
  logic [N*AW-1:0] rangeBase, rangeLimit;
  logic [N-1:0]  enA;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic [AW-1:0] baseA [N];
  logic [AW-1:0] limA  [N];

  always_comb
    for (int k = 0; k < N; k++) begin
      rangeBase[k*AW +: AW]  = baseA[k];
      rangeLimit[k*AW +: AW] = limA[k];
    end

  range_clear_seq #(.NUM_RANGES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rangeBase(rangeBase), .rangeLimit(rangeLimit),
    .rangeEnable(enA), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy)
  );

  int nChecks = 0, nFails = 0, dataErr = 0, holdErr = 0;
  bit readyAlways = 1'b1, prevStall = 1'b0, finished = 1'b0;
  logic [AW-1:0] prevAddr;
  logic [AW-1:0] got[$];
  logic [AW-1:0] expQ[$];

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) wrReady <= readyAlways ? 1'b1 : (($urandom % 3) != 0);

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (prevStall && (!wrValid || wrAddr != prevAddr)) holdErr++;
      if (wrValid && wrReady) begin
        got.push_back(wrAddr);
        if (wrData != '0) dataErr++;
      end
      prevStall = wrValid && !wrReady;
      prevAddr  = wrAddr;
    end
  end

  function automatic void addRange(int i);
    if (enA[i])
      for (int a = int'(baseA[i]); a <= int'(limA[i]); a++) expQ.push_back(AW'(a));
  endfunction

  function automatic void addSweep();
    for (int i = 0; i < N; i++) addRange(i);
  endfunction

  task automatic regWrite(logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic waitIdleCompare(string req);
    int bad = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(req, "write count", got.size(), expQ.size());
    for (int i = 0; i < got.size() && i < expQ.size(); i++)
      if (got[i] != expQ[i]) bad++;
    chk(req, "address order mismatches", bad, 0);
    chk(req, "control word after completion", regRdData, 0);
    got.delete(); expQ.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; enA = '1;
    for (int k = 0; k < N; k++) begin baseA[k] = AW'(k*32); limA[k] = AW'(k*32 + 3); end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "control word", regRdData, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "wrValid", wrValid, 0);

    // R2 / R9 single range
    baseA[2] = 16'd500; limA[2] = 16'd505;
    regWrite(32'h4);
    chk("R2", "bit 2 set after write", regRdData, 32'h4);
    chk("R9", "busy while pending", busy, 1);
    repeat (3) @(negedge clk);
    chk("R2", "bit 2 held mid-range", regRdData[2], 1);
    addRange(2);
    waitIdleCompare("R2");
    chk("R9", "busy after done", busy, 0);

    // R4 several per-range bits: 5,1,3 -> 1,3,5
    readyAlways = 1'b0;
    regWrite(32'h2A);
    addRange(1); addRange(3); addRange(5);
    waitIdleCompare("R4");

    // R5 / R6 sweep with disabled ranges
    enA = 8'b1010_1101;
    regWrite(32'h8000_0000);
    repeat (4) @(negedge clk);
    chk("R5", "bit 31 held mid-sweep", regRdData[31], 1);
    addSweep();
    waitIdleCompare("R5/R6 sweep");

    // R6 per-range bit on a disabled range
    regWrite(32'h10);
    chk("R6", "disabled bit visible one cycle", regRdData, 32'h10);
    @(negedge clk);
    chk("R6", "disabled bit cleared", regRdData, 0);
    chk("R6", "no writes for disabled range", got.size(), 0);

    // R7 reserved bits
    regWrite(32'h7FFF_FF00);
    chk("R7", "reserved bits read", regRdData, 0);
    chk("R7", "busy after reserved write", busy, 0);
    enA = '1;

    // R8 no abort, no restart
    baseA[0] = 16'd0; limA[0] = 16'd29;
    regWrite(32'h1);
    repeat (4) @(negedge clk);
    regWrite(32'h0);
    chk("R8", "bit 0 survives write of 0", regRdData[0], 1);
    repeat (3) @(negedge clk);
    regWrite(32'h1);
    addRange(0);
    waitIdleCompare("R8");

    // R10 per-range request during a sweep
    readyAlways = 1'b1;
    baseA[0] = 16'd100; limA[0] = 16'd119;
    regWrite(32'h8000_0000);
    repeat (5) @(negedge clk);
    regWrite(32'h80);
    addRange(0); addRange(7);
    for (int i = 1; i < N; i++) addRange(i);
    waitIdleCompare("R10");

    // random rounds, R2 R3 R4 R5 R6
    readyAlways = 1'b0;
    for (int r = 0; r < 20; r++) begin
      int kind = $urandom % 3;
      logic [7:0] mask = 8'($urandom);
      enA = 8'($urandom);
      for (int k = 0; k < N; k++) begin
        baseA[k] = AW'(k*40 + ($urandom % 10));
        limA[k]  = baseA[k] + AW'($urandom % 5);
      end
      if (kind == 0) begin
        regWrite(32'h8000_0000); addSweep();
      end else if (kind == 1) begin
        regWrite({24'h0, mask});
        for (int i = 0; i < N; i++) if (mask[i]) addRange(i);
      end else begin
        regWrite({24'h80_0000, mask});
        for (int i = 0; i < N; i++) if (mask[i]) addRange(i);
        addSweep();
      end
      waitIdleCompare("R4/R5 random");
    end

    chk("R2", "nonzero write data seen", dataErr, 0);
    chk("R3", "stall hold violations", holdErr, 0);
    summary();
  end
endmodule